// File: doc/BRIEF.md
# Cursor Position Shadow Register Unit

This block keeps the settings of a hardware cursor for a raster display controller: where the cursor sits on screen, which part of the cursor image is shown first (the clip offset), and a small bank of cursor colours. Software writes these settings through a simple write port with an address, a data word and a write strobe. A separate read port returns the last value written to each register.

The block decides when a written value reaches the overlay logic. A one-bit frame-sync mode input selects the timing. With the mode at 0, a write reaches the active outputs at the next clock edge, even in the middle of a frame. With the mode at 1, a position write is held until the next rising edge of the vertical-blank input. A clip write is held longer still: it commits at a blanking edge only when a position write has followed it. Software that writes the clip first and the position second therefore never shows a frame that pairs a new clip with an old position. Colour writes always take effect at once.

Top module: `cursor_shadow_regs`

## Requirements
- R1: After reset, every active output is zero and a read of the position, clip and colour registers returns zero.
- R2: The position register is at word address 0. It holds X in bits 9:0 and Y in bits 25:16. Writes to every other bit are dropped, and those bits read back as 0.
- R3: With frame-sync mode 0, a position write appears on the active position outputs after the clock edge that takes the write.
- R4: The clip register is at word address 1 and has the same layout as the position register. With frame-sync mode 0, a clip write appears on the active clip outputs after the clock edge that takes the write.
- R5: With frame-sync mode 1, a position write leaves the active position unchanged until a clock edge that sees vertical-blank high after it was low. That edge commits the pending value. Later cycles in which vertical-blank stays high change nothing.
- R6: With frame-sync mode 1, a pending clip value stays inactive across a blanking edge unless a position write was taken after the clip write. When that condition holds, the clip commits at the same edge as that position.
- R7: With frame-sync mode 1, a clip write taken after the last position write cancels any earlier arming. The clip commits only at a blanking edge that comes after a further position write.
- R8: Colour register k is at word address 2+k. It holds red in bits 7:0, green in bits 15:8 and blue in bits 23:16. It drives active colour k at once in either mode. Bits 31:24 read back as 0.
- R9: A read returns the pending (most recently written) value, even while a frame-synchronised write is still waiting for its blanking edge.
- R10: A position write taken in the same cycle as a blanking edge does not commit at that edge. The edge commits the value pending before the write, and the new value waits for the next blanking edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe, one write per cycle high |
| wr_addr | input | ADDR_W | Word address of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | ADDR_W | Word address of the read |
| rd_data | output | 32 | Pending value of the addressed register (combinational) |
| frame_sync | input | 1 | 1 = position and clip wait for vertical blank, 0 = take effect at once |
| vblank | input | 1 | Vertical-blank level from the timing generator |
| act_pos_x | output | COORD_W | Active cursor X |
| act_pos_y | output | COORD_W | Active cursor Y |
| act_clip_x | output | COORD_W | Active clip X offset |
| act_clip_y | output | COORD_W | Active clip Y offset |
| act_pal | output | NUM_PAL*3*COLOR_W | Active colours, entry k in slice k |

## Verification
A write taken at a clock edge is due on the active outputs right after that edge in mode 0, and for colours in either mode. A frame-synchronised value is due right after the first edge that sees vertical-blank high. Read data depends only on the current read address and is valid within the same cycle. The bench changes its inputs on the falling edge, so each write or blanking edge happens at the next rising edge. It compares results on the falling edge that follows, exactly one register stage after the stimulus. Where a value must not yet have moved, it also checks again after several idle cycles.

// File: rtl/cursor_shadow_pkg.sv
package cursor_shadow_pkg;

   // register word width seen by software
   localparam int unsigned REG_W = 32;
   // bit position of the second coordinate inside a coordinate word
   localparam int unsigned Y_LSB = 16;

   // word addresses
   localparam int unsigned ADDR_POS  = 0;
   localparam int unsigned ADDR_CLIP = 1;
   localparam int unsigned ADDR_PAL0 = 2;

   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_POS  = 2'd1,
      SEL_CLIP = 2'd2,
      SEL_PAL  = 2'd3
   } reg_sel_e;

endpackage

// File: rtl/cursor_vblank_edge.sv
module cursor_vblank_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic vblank,
   output logic blank_rise
);

   logic vblank_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vblank_q <= 1'b0;
      else        vblank_q <= vblank;
   end

   assign blank_rise = vblank & ~vblank_q;

endmodule

// File: rtl/cursor_xy_shadow.sv
module cursor_xy_shadow #(
   parameter int unsigned COORD_W    = 10,
   parameter bit          COMMIT_GATE = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [COORD_W-1:0] wr_x,
   input  logic [COORD_W-1:0] wr_y,
   input  logic               frame_sync,
   input  logic               blank_rise,
   input  logic               arm_evt,
   output logic [COORD_W-1:0] pend_x,
   output logic [COORD_W-1:0] pend_y,
   output logic [COORD_W-1:0] act_x,
   output logic [COORD_W-1:0] act_y
);

   logic pend_flag;
   logic gate_ok;
   logic do_commit;

   generate
      if (COMMIT_GATE) begin : g_gated
         logic armed_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                       armed_q <= 1'b0;
            else if (wr_en)                   armed_q <= 1'b0;
            else if (blank_rise && armed_q && pend_flag) armed_q <= 1'b0;
            else if (arm_evt && pend_flag)    armed_q <= 1'b1;
         end
         assign gate_ok = armed_q;
      end else begin : g_free
         logic unused_arm;
         assign unused_arm = arm_evt;
         assign gate_ok    = 1'b1;
      end
   endgenerate

   assign do_commit = blank_rise & pend_flag & gate_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_x    <= '0;
         pend_y    <= '0;
         act_x     <= '0;
         act_y     <= '0;
         pend_flag <= 1'b0;
      end else begin
         if (wr_en) begin
            pend_x <= wr_x;
            pend_y <= wr_y;
         end
         if (wr_en && !frame_sync) begin
            act_x     <= wr_x;
            act_y     <= wr_y;
            pend_flag <= 1'b0;
         end else begin
            if (do_commit) begin
               act_x <= pend_x;
               act_y <= pend_y;
            end
            if (wr_en)          pend_flag <= 1'b1;
            else if (do_commit) pend_flag <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/cursor_palette_bank.sv
module cursor_palette_bank #(
   parameter int unsigned NUM_PAL = 2,
   parameter int unsigned COLOR_W = 8,
   parameter int unsigned ADDR_W  = 3,
   localparam int unsigned PAL_W  = 3 * COLOR_W
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [ADDR_W-1:0]        wr_idx,
   input  logic [PAL_W-1:0]         wr_color,
   input  logic [ADDR_W-1:0]        rd_idx,
   output logic [PAL_W-1:0]         rd_color,
   output logic [NUM_PAL*PAL_W-1:0] act_pal
);

   logic [PAL_W-1:0] entry [NUM_PAL];

   generate
      for (genvar k = 0; k < NUM_PAL; k++) begin : g_entry
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                  entry[k] <= '0;
            else if (wr_en && wr_idx == ADDR_W'(k))      entry[k] <= wr_color;
         end
         assign act_pal[k*PAL_W +: PAL_W] = entry[k];
      end
   endgenerate

   always_comb begin
      rd_color = '0;
      for (int k = 0; k < NUM_PAL; k++) begin
         if (rd_idx == ADDR_W'(k)) rd_color = entry[k];
      end
   end

endmodule

// File: rtl/cursor_shadow_regs.sv
module cursor_shadow_regs
   import cursor_shadow_pkg::*;
#(
   parameter int unsigned COORD_W = 10,
   parameter int unsigned COLOR_W = 8,
   parameter int unsigned NUM_PAL = 2,
   parameter int unsigned ADDR_W  = 3,
   localparam int unsigned PAL_W  = 3 * COLOR_W
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [ADDR_W-1:0]        wr_addr,
   input  logic [REG_W-1:0]         wr_data,
   input  logic [ADDR_W-1:0]        rd_addr,
   output logic [REG_W-1:0]         rd_data,
   input  logic                     frame_sync,
   input  logic                     vblank,
   output logic [COORD_W-1:0]       act_pos_x,
   output logic [COORD_W-1:0]       act_pos_y,
   output logic [COORD_W-1:0]       act_clip_x,
   output logic [COORD_W-1:0]       act_clip_y,
   output logic [NUM_PAL*PAL_W-1:0] act_pal
);

   // elaboration-time parameter checks
   generate
      if (COORD_W < 1 || COORD_W > Y_LSB) begin : g_bad_coord
         $error("COORD_W must lie in 1..16");
      end
      if (PAL_W > REG_W || COLOR_W < 1) begin : g_bad_color
         $error("three colour fields must fit in one register word");
      end
      if (NUM_PAL < 1 || (ADDR_PAL0 + NUM_PAL) > (1 << ADDR_W)) begin : g_bad_addr
         $error("ADDR_W too narrow for the colour registers");
      end
   endgenerate

   reg_sel_e          wr_sel;
   reg_sel_e          rd_sel;
   logic [ADDR_W-1:0] wr_pal_idx;
   logic [ADDR_W-1:0] rd_pal_idx;
   logic              blank_rise;

   logic [COORD_W-1:0] pend_pos_x, pend_pos_y;
   logic [COORD_W-1:0] pend_clip_x, pend_clip_y;
   logic [PAL_W-1:0]   rd_color;

   function automatic reg_sel_e decode(input logic [ADDR_W-1:0] a);
      if (int'(a) == ADDR_POS)       return SEL_POS;
      else if (int'(a) == ADDR_CLIP) return SEL_CLIP;
      else if (int'(a) >= ADDR_PAL0 && int'(a) < ADDR_PAL0 + NUM_PAL) return SEL_PAL;
      else                           return SEL_NONE;
   endfunction

   function automatic logic [REG_W-1:0] pack_xy(input logic [COORD_W-1:0] x,
                                                input logic [COORD_W-1:0] y);
      logic [REG_W-1:0] w;
      w = '0;
      w[COORD_W-1:0]         = x;
      w[Y_LSB +: COORD_W]    = y;
      return w;
   endfunction

   assign wr_sel     = decode(wr_addr);
   assign rd_sel     = decode(rd_addr);
   assign wr_pal_idx = wr_addr - ADDR_W'(ADDR_PAL0);
   assign rd_pal_idx = rd_addr - ADDR_W'(ADDR_PAL0);

   cursor_vblank_edge u_edge (
      .clk        (clk),
      .rst_n      (rst_n),
      .vblank     (vblank),
      .blank_rise (blank_rise)
   );

   cursor_xy_shadow #(
      .COORD_W     (COORD_W),
      .COMMIT_GATE (1'b0)
   ) u_pos (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en && wr_sel == SEL_POS),
      .wr_x       (wr_data[COORD_W-1:0]),
      .wr_y       (wr_data[Y_LSB +: COORD_W]),
      .frame_sync (frame_sync),
      .blank_rise (blank_rise),
      .arm_evt    (1'b0),
      .pend_x     (pend_pos_x),
      .pend_y     (pend_pos_y),
      .act_x      (act_pos_x),
      .act_y      (act_pos_y)
   );

   cursor_xy_shadow #(
      .COORD_W     (COORD_W),
      .COMMIT_GATE (1'b1)
   ) u_clip (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en && wr_sel == SEL_CLIP),
      .wr_x       (wr_data[COORD_W-1:0]),
      .wr_y       (wr_data[Y_LSB +: COORD_W]),
      .frame_sync (frame_sync),
      .blank_rise (blank_rise),
      .arm_evt    (wr_en && wr_sel == SEL_POS),
      .pend_x     (pend_clip_x),
      .pend_y     (pend_clip_y),
      .act_x      (act_clip_x),
      .act_y      (act_clip_y)
   );

   cursor_palette_bank #(
      .NUM_PAL (NUM_PAL),
      .COLOR_W (COLOR_W),
      .ADDR_W  (ADDR_W)
   ) u_pal (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en && wr_sel == SEL_PAL),
      .wr_idx   (wr_pal_idx),
      .wr_color (wr_data[PAL_W-1:0]),
      .rd_idx   (rd_pal_idx),
      .rd_color (rd_color),
      .act_pal  (act_pal)
   );

   always_comb begin
      unique case (rd_sel)
         SEL_POS:  rd_data = pack_xy(pend_pos_x, pend_pos_y);
         SEL_CLIP: rd_data = pack_xy(pend_clip_x, pend_clip_y);
         SEL_PAL:  rd_data = REG_W'(rd_color);
         default:  rd_data = '0;
      endcase
   end

endmodule

// File: rtl/cursor_shadow_regs_chk.sv
module cursor_shadow_regs_chk #(
   parameter int unsigned COORD_W = 10,
   parameter int unsigned COLOR_W = 8,
   parameter int unsigned NUM_PAL = 2,
   parameter int unsigned ADDR_W  = 3,
   localparam int unsigned PAL_W  = 3 * COLOR_W
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     wr_en,
   input logic [ADDR_W-1:0]        wr_addr,
   input logic [31:0]              wr_data,
   input logic [ADDR_W-1:0]        rd_addr,
   input logic [31:0]              rd_data,
   input logic                     frame_sync,
   input logic                     vblank,
   input logic [COORD_W-1:0]       act_pos_x,
   input logic [COORD_W-1:0]       act_pos_y,
   input logic [COORD_W-1:0]       act_clip_x,
   input logic [COORD_W-1:0]       act_clip_y,
   input logic [NUM_PAL*PAL_W-1:0] act_pal
);

   logic vb_seen;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vb_seen <= 1'b0;
      else        vb_seen <= vblank;
   end

   wire edge_now = vblank && !vb_seen;
   wire pos_now  = wr_en && wr_addr == ADDR_W'(0) && !frame_sync;
   wire clip_now = wr_en && wr_addr == ADDR_W'(1) && !frame_sync;

   assert_pos_direct_R3: assert property (@(posedge clk) disable iff (!rst_n)
      pos_now |=> (act_pos_x == $past(wr_data[COORD_W-1:0])) &&
                  (act_pos_y == $past(wr_data[16 +: COORD_W])));

   assert_clip_direct_R4: assert property (@(posedge clk) disable iff (!rst_n)
      clip_now |=> (act_clip_x == $past(wr_data[COORD_W-1:0])) &&
                   (act_clip_y == $past(wr_data[16 +: COORD_W])));

   assert_pos_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!pos_now && !edge_now) |=> $stable({act_pos_x, act_pos_y}));

   assert_clip_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!clip_now && !edge_now) |=> $stable({act_clip_x, act_clip_y}));

   assert_read_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_addr > ADDR_W'(1 + NUM_PAL)) |-> (rd_data == 32'd0));

   generate
      for (genvar k = 0; k < NUM_PAL; k++) begin : g_pal_chk
         assert_pal_direct_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_addr == ADDR_W'(2 + k)) |=>
               (act_pal[k*PAL_W +: PAL_W] == $past(wr_data[PAL_W-1:0])));
      end
   endgenerate

endmodule

bind cursor_shadow_regs cursor_shadow_regs_chk #(
   .COORD_W (COORD_W),
   .COLOR_W (COLOR_W),
   .NUM_PAL (NUM_PAL),
   .ADDR_W  (ADDR_W)
) chk_i (.*);

// File: tb/cursor_shadow_regs_tb_top.sv
`timescale 1ns/1ps
module cursor_shadow_regs_tb_top;

   localparam int unsigned COORD_W = 10;
   localparam int unsigned COLOR_W = 8;
   localparam int unsigned NUM_PAL = 2;
   localparam int unsigned ADDR_W  = 3;
   localparam int unsigned PAL_W   = 3 * COLOR_W;

   logic                     clk = 1'b0;
   logic                     rst_n = 1'b0;
   logic                     wr_en = 1'b0;
   logic [ADDR_W-1:0]        wr_addr = '0;
   logic [31:0]              wr_data = '0;
   logic [ADDR_W-1:0]        rd_addr = '0;
   logic [31:0]              rd_data;
   logic                     frame_sync = 1'b0;
   logic                     vblank = 1'b0;
   logic [COORD_W-1:0]       act_pos_x, act_pos_y, act_clip_x, act_clip_y;
   logic [NUM_PAL*PAL_W-1:0] act_pal;

   int compared   = 0;
   int mismatched = 0;
   bit done       = 1'b0;

   always #2.5 clk = ~clk;

   cursor_shadow_regs #(
      .COORD_W (COORD_W), .COLOR_W (COLOR_W), .NUM_PAL (NUM_PAL), .ADDR_W (ADDR_W)
   ) dut_i (
      .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_addr (wr_addr),
      .wr_data (wr_data), .rd_addr (rd_addr), .rd_data (rd_data),
      .frame_sync (frame_sync), .vblank (vblank),
      .act_pos_x (act_pos_x), .act_pos_y (act_pos_y),
      .act_clip_x (act_clip_x), .act_clip_y (act_clip_y), .act_pal (act_pal)
   );

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      compared++;
      if (got !== exp) begin
         mismatched++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, got, exp);
      end
   endtask

   function automatic logic [31:0] pos_word();
      return {6'd0, act_pos_y, 6'd0, act_pos_x};
   endfunction
   function automatic logic [31:0] clip_word();
      return {6'd0, act_clip_y, 6'd0, act_clip_x};
   endfunction

   task automatic reg_write(input int a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = ADDR_W'(a); wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic reg_read(input int a, output logic [31:0] d);
      rd_addr = ADDR_W'(a);
      #0.5;
      d = rd_data;
   endtask

   task automatic blank_pulse();
      @(negedge clk); vblank = 1'b1;
      @(negedge clk); vblank = 1'b0;
      @(negedge clk);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic t_reset();
      logic [31:0] r;
      check("R1 pos", pos_word(), 32'h0);
      check("R1 clip", clip_word(), 32'h0);
      check("R1 pal", 32'(act_pal), 32'h0);
      reg_read(0, r); check("R1 read pos", r, 32'h0);
      reg_read(1, r); check("R1 read clip", r, 32'h0);
      reg_read(3, r); check("R1 read pal1", r, 32'h0);
   endtask

   task automatic t_immediate();
      logic [31:0] r;
      frame_sync = 1'b0;
      reg_write(0, 32'hFFFF_FFFF);
      check("R2 pos all ones", pos_word(), 32'h03FF_03FF);
      reg_read(0, r); check("R2 reserved read zero", r, 32'h03FF_03FF);
      reg_write(0, 32'h0123_0045);
      check("R3 pos immediate", pos_word(), 32'h0123_0045);
      reg_write(1, 32'hFC07_F009);
      check("R4 clip immediate", clip_word(), 32'h0007_0009);
   endtask

   task automatic t_pos_sync();
      logic [31:0] r;
      frame_sync = 1'b1;
      reg_write(0, 32'h0050_0060);
      idle(3);
      check("R5 pos held", pos_word(), 32'h0123_0045);
      reg_read(0, r); check("R9 read pending", r, 32'h0050_0060);
      @(negedge clk); vblank = 1'b1;
      @(negedge clk);
      check("R5 pos at edge", pos_word(), 32'h0050_0060);
      wr_en = 1'b1; wr_addr = '0; wr_data = 32'h0011_0022;
      @(negedge clk); wr_en = 1'b0;
      idle(2);
      check("R5 level no commit", pos_word(), 32'h0050_0060);
      vblank = 1'b0;
      blank_pulse();
      check("R5 next edge", pos_word(), 32'h0011_0022);
   endtask

   task automatic t_clip_gate();
      frame_sync = 1'b1;
      reg_write(1, 32'h0002_0003);
      blank_pulse();
      check("R6 clip held w/o pos", clip_word(), 32'h0007_0009);
      reg_write(0, 32'h0001_0001);
      blank_pulse();
      check("R6 clip commits", clip_word(), 32'h0002_0003);
      check("R6 pos commits", pos_word(), 32'h0001_0001);
   endtask

   task automatic t_clip_order();
      frame_sync = 1'b1;
      reg_write(0, 32'h0004_0004);
      reg_write(1, 32'h0005_0006);
      blank_pulse();
      check("R7 pos moved", pos_word(), 32'h0004_0004);
      check("R7 clip kept", clip_word(), 32'h0002_0003);
      reg_write(0, 32'h0008_0008);
      blank_pulse();
      check("R7 clip after pos", clip_word(), 32'h0005_0006);
   endtask

   task automatic t_palette();
      logic [31:0] r;
      frame_sync = 1'b1;
      reg_write(2, 32'hAB11_2233);
      check("R8 pal0 immediate", 32'(act_pal[PAL_W-1:0]), 32'h0011_2233);
      reg_read(2, r); check("R8 pal0 read", r, 32'h0011_2233);
      frame_sync = 1'b0;
      reg_write(3, 32'h0044_5566);
      check("R8 pal1 immediate", 32'(act_pal[PAL_W +: PAL_W]), 32'h0044_5566);
      check("R8 pal0 untouched", 32'(act_pal[PAL_W-1:0]), 32'h0011_2233);
   endtask

   task automatic t_same_cycle();
      logic [31:0] r;
      frame_sync = 1'b1;
      reg_write(0, 32'h0020_0020);
      @(negedge clk);
      vblank = 1'b1; wr_en = 1'b1; wr_addr = '0; wr_data = 32'h0030_0030;
      @(negedge clk);
      wr_en = 1'b0; vblank = 1'b0;
      check("R10 old value commits", pos_word(), 32'h0020_0020);
      reg_read(0, r); check("R10 new value pending", r, 32'h0030_0030);
      blank_pulse();
      check("R10 new value next edge", pos_word(), 32'h0030_0030);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         mismatched++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(1);
      t_reset();
      t_immediate();
      t_pos_sync();
      t_clip_gate();
      t_clip_order();
      t_palette();
      t_same_cycle();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

endmodule